// File: doc/BRIEF.md
# FIFO Stall Watchdog

This block watches a set of FIFOs, one transmit and one receive by default, and flags any of them that stops moving. For each FIFO a prescaler turns the clock into coarse time ticks. A hung counter counts those ticks for as long as the FIFO sees neither a push nor a pop. When the count reaches a programmed 8-bit threshold, the block latches a hung event into a raw status bit.

The tick period scales by a power of two. The prescaler limit is a base count, 88000 by default, shifted right by a 3-bit shift field. Any activity on a FIFO restarts both of its counters. After the threshold is reached, the counter holds until activity returns, so one stall gives exactly one event. Each FIFO has a raw status bit, an enable bit and a masked status bit. A write-one clear input resets the raw bit. A single interrupt line is the OR of the masked bits.

A global enable gates the whole function. While it is low, both counters of every FIFO are held at zero.

Top module: `fifo_hung_wdg`

## Requirements
- R1: After reset all raw status bits and masked status bits are 0 and `hung_irq` is low.
- R2: The prescaler limit L equals BASE_COUNT shifted right by `tick_shift`. While a FIFO is stalled, a tick occurs every L+1 clock cycles, counted from the edge that restarted its counters.
- R3: While `timeout_en` is 0 the counters are held at zero and no raw bit is set. Counting starts on the first clock edge at which `timeout_en` is sampled high.
- R4: Channel index 0 is transmit and index 1 is receive. Each index has its own counters and its own status bits, and activity on one index does not affect the other.
- R5: Masked status bit i is 1 exactly when raw bit i and `int_ena` bit i are both 1. `hung_irq` is the OR of all masked bits.
- R6: A 1 on `int_clr` bit i, sampled at a clock edge, clears raw bit i at that edge.
- R7: If a set and a clear of the same raw bit happen at the same edge, the raw bit ends at 1.
- R8: A 1 on `fifo_activity` bit i at an edge clears that channel's prescaler and hung counter at that edge. If the FIFO then stalls from the next edge on, raw bit i is set at the threshold × (L+1)-th edge after the restart.
- R9: After a hung event, the hung counter saturates at the threshold. Raw bit i is not set again until activity restarts the channel.
- R10: A threshold of 0 never sets a raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_en | input | 1 | Global enable of the stall watchdog |
| threshold | input | THR_W | Tick count that marks a FIFO as hung |
| tick_shift | input | SHIFT_W | Right shift applied to BASE_COUNT to form the tick limit |
| fifo_activity | input | NUM_CH | Per-FIFO push or pop strobe; bit 0 transmit, bit 1 receive |
| int_ena | input | NUM_CH | Interrupt enable per FIFO |
| int_clr | input | NUM_CH | Write-one-to-clear strobe for the raw bits |
| int_raw | output | NUM_CH | Raw hung status per FIFO |
| int_st | output | NUM_CH | Masked hung status per FIFO |
| hung_irq | output | 1 | OR of the masked status bits |

## Verification
The bench builds the block with BASE_COUNT set to 64 and keeps THR_W at 8 and SHIFT_W at 3. The tick limit then runs from 64 at shift 0 down to 0 at shift 7. This covers every tick period from 65 cycles down to one tick per cycle, and the full threshold of 255 fits in a few thousand cycles. With these values the exact edge of each hung event can be measured against threshold × (L+1) for every shift. The same values reach the one-cycle tick period, where a set and a clear can be placed on the same edge.

// File: rtl/fifo_hung_wdg_pkg.sv
package fifo_hung_wdg_pkg;

  // Tick limit: base count scaled down by a power of two.
  function automatic int unsigned tick_limit(input int unsigned base,
                                             input int unsigned shift);
    return base >> shift;
  endfunction

  // Next value of a raw status bit: a set overrides a clear.
  function automatic logic raw_next(input logic cur,
                                    input logic set,
                                    input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/hung_prescaler.sv
module hung_prescaler #(
  parameter int unsigned BASE_COUNT = 88000,
  parameter int unsigned SHIFT_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  import fifo_hung_wdg_pkg::*;

  localparam int unsigned PRE_W = $clog2(BASE_COUNT + 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'(tick_limit(BASE_COUNT, 32'(shift)));
    tick  = !restart && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + PRE_W'(1);
  end
endmodule

// File: rtl/hung_counter.sv
module hung_counter #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [THR_W-1:0] threshold,
  output logic             hit
);
  logic [THR_W-1:0] cnt;
  logic [THR_W:0]   cnt_inc;
  logic             sat;

  always_comb begin
    cnt_inc = {1'b0, cnt} + {{THR_W{1'b0}}, 1'b1};
    sat     = cnt >= threshold;
    hit     = !restart && tick && !sat && (cnt_inc == {1'b0, threshold});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (tick && !sat)  cnt <= cnt_inc[THR_W-1:0];
  end
endmodule

// File: rtl/hung_status_bit.sv
module hung_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ena,
  output logic raw,
  output logic st
);
  import fifo_hung_wdg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= 1'b0;
    else        raw <= raw_next(raw, set, clr);
  end

  assign st = raw & ena;
endmodule

// File: rtl/fifo_hung_wdg.sv
module fifo_hung_wdg #(
  parameter int unsigned BASE_COUNT = 88000,
  parameter int unsigned THR_W      = 8,
  parameter int unsigned SHIFT_W    = 3,
  parameter int unsigned NUM_CH     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               timeout_en,
  input  logic [THR_W-1:0]   threshold,
  input  logic [SHIFT_W-1:0] tick_shift,
  input  logic [NUM_CH-1:0]  fifo_activity,
  input  logic [NUM_CH-1:0]  int_ena,
  input  logic [NUM_CH-1:0]  int_clr,
  output logic [NUM_CH-1:0]  int_raw,
  output logic [NUM_CH-1:0]  int_st,
  output logic               hung_irq
);
  // Named internal events, observed by the bound checker.
  logic [NUM_CH-1:0] restart_w;
  logic [NUM_CH-1:0] tick_w;
  logic [NUM_CH-1:0] hit_w;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign restart_w[ch] = !timeout_en || fifo_activity[ch];

    hung_prescaler #(
      .BASE_COUNT(BASE_COUNT),
      .SHIFT_W   (SHIFT_W)
    ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart_w[ch]),
      .shift  (tick_shift),
      .tick   (tick_w[ch])
    );

    hung_counter #(
      .THR_W(THR_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart_w[ch]),
      .tick     (tick_w[ch]),
      .threshold(threshold),
      .hit      (hit_w[ch])
    );

    hung_status_bit u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (hit_w[ch]),
      .clr  (int_clr[ch]),
      .ena  (int_ena[ch]),
      .raw  (int_raw[ch]),
      .st   (int_st[ch])
    );
  end

  assign hung_irq = |int_st;
endmodule

// File: rtl/fifo_hung_wdg_chk.sv
module fifo_hung_wdg_chk #(
  parameter int unsigned THR_W  = 8,
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              timeout_en,
  input logic [THR_W-1:0]  threshold,
  input logic [NUM_CH-1:0] fifo_activity,
  input logic [NUM_CH-1:0] int_ena,
  input logic [NUM_CH-1:0] int_clr,
  input logic [NUM_CH-1:0] int_raw,
  input logic [NUM_CH-1:0] int_st,
  input logic              hung_irq,
  input logic [NUM_CH-1:0] hit_w
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_RAW_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_raw[i]) |-> $past(timeout_en)); // R3

    AST_ST_IMPLIES_RAW_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      int_st[i] |-> (int_raw[i] && int_ena[i])); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr[i] && !hit_w[i]) |=> !int_raw[i]); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w[i] |=> int_raw[i]); // R7

    AST_ACTIVITY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_activity[i] |-> !hit_w[i]); // R8

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w[i] && !fifo_activity[i]) |=>
        (!hit_w[i] || (threshold != $past(threshold)))); // R9

    AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (threshold == '0) |-> !hit_w[i]); // R10
  end

  AST_IRQ_FROM_ST: assert property (@(posedge clk) disable iff (!rst_n)
    hung_irq |-> (int_st != '0)); // R5
endmodule

bind fifo_hung_wdg fifo_hung_wdg_chk #(
  .THR_W (THR_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .timeout_en   (timeout_en),
  .threshold    (threshold),
  .fifo_activity(fifo_activity),
  .int_ena      (int_ena),
  .int_clr      (int_clr),
  .int_raw      (int_raw),
  .int_st       (int_st),
  .hung_irq     (hung_irq),
  .hit_w        (hit_w)
);

// File: tb/tb_fifo_hung_wdg.sv
module tb_fifo_hung_wdg;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       timeout_en;
  logic [7:0] threshold;
  logic [2:0] tick_shift;
  logic [1:0] fifo_activity;
  logic [1:0] int_ena;
  logic [1:0] int_clr;
  logic [1:0] int_raw;
  logic [1:0] int_st;
  logic       hung_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_hung_wdg #(.BASE_COUNT(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .timeout_en(timeout_en), .threshold(threshold),
    .tick_shift(tick_shift), .fifo_activity(fifo_activity), .int_ena(int_ena),
    .int_clr(int_clr), .int_raw(int_raw), .int_st(int_st), .hung_irq(hung_irq)
  );

  // Vector table: {shift[10:8], threshold[7:0]}
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'd3}, {3'd3, 8'd10}, {3'd6, 8'd7},
    {3'd7, 8'd1}, {3'd2, 8'd255}, {3'd5, 8'd4}
  };

  function automatic int expect_edges(input int sh, input int thr);
    return thr * ((BASE / (1 << sh)) + 1);
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive at the negedge, one edge of activity plus clear on both channels.
  task automatic restart_all();
    @(negedge clk);
    fifo_activity = 2'b11;
    int_clr = 2'b11;
    @(negedge clk);
    fifo_activity = 2'b00;
    int_clr = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; timeout_en = 1'b0; threshold = 8'd0; tick_shift = 3'd0;
    fifo_activity = 2'b00; int_ena = 2'b11; int_clr = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 raw after reset", int_raw, 0);
    check("R1 st after reset", int_st, 0);
    check("R1 irq after reset", hung_irq, 0);
    rst_n = 1'b1;
    timeout_en = 1'b1;

    // R2 R8: measure the edge of the hung event for each vector
    for (int v = 0; v < 6; v++) begin
      int k_tx, k_rx, sh, thr;
      sh = int'(VEC[v][10:8]);
      thr = int'(VEC[v][7:0]);
      tick_shift = VEC[v][10:8];
      threshold = VEC[v][7:0];
      @(negedge clk);
      fifo_activity = 2'b11;
      int_clr = 2'b11;
      k_tx = -1; k_rx = -1;
      @(posedge clk);            // restart edge E0
      @(negedge clk);
      fifo_activity = 2'b00;
      int_clr = 2'b00;
      for (int k = 1; k <= 6000; k++) begin
        @(posedge clk); #1;
        if (k_tx < 0 && int_raw[0]) k_tx = k;
        if (k_rx < 0 && int_raw[1]) k_rx = k;
        if (k_tx > 0 && k_rx > 0) break;
      end
      check($sformatf("R2 R8 tx edge shift %0d thr %0d", sh, thr), k_tx, expect_edges(sh, thr));
      check($sformatf("R4 rx edge shift %0d thr %0d", sh, thr), k_rx, expect_edges(sh, thr));
    end

    // R9: after the event, cleared raw stays low with no activity
    @(negedge clk);
    int_clr = 2'b11;
    @(negedge clk);
    int_clr = 2'b00;
    idle(200);
    check("R9 no refire while stalled", int_raw, 0);

    // R10: threshold zero never fires
    threshold = 8'd0; tick_shift = 3'd7;
    restart_all();
    idle(100);
    check("R10 zero threshold", int_raw, 0);

    // R3: disabled for a long stall, then counting restarts on enable
    threshold = 8'd1;
    timeout_en = 1'b0;
    restart_all();
    idle(300);
    check("R3 disabled no event", int_raw, 0);
    @(negedge clk);
    timeout_en = 1'b1;
    @(posedge clk); #1;
    check("R3 event one edge after enable", int_raw, 3);

    // R6: write-one clear
    @(negedge clk);
    int_clr = 2'b01;
    @(negedge clk);
    int_clr = 2'b00;
    check("R6 clear tx only", int_raw, 2);

    // R8 R4: tx kept alive by activity, rx stalls
    threshold = 8'd8; tick_shift = 3'd7;
    restart_all();
    for (int i = 0; i < 100; i++) begin
      fifo_activity = (i % 4 == 0) ? 2'b01 : 2'b00;
      @(negedge clk);
    end
    fifo_activity = 2'b00;
    check("R8 active tx stays quiet", int_raw[0], 0);
    check("R4 stalled rx fires", int_raw[1], 1);

    // R7: set and clear on the same edge (thr 4, period 1 -> edge E4)
    threshold = 8'd4; tick_shift = 3'd7;
    @(negedge clk);
    fifo_activity = 2'b11; int_clr = 2'b11;
    @(negedge clk);            // E0 passed
    fifo_activity = 2'b00; int_clr = 2'b00;
    idle(2);                   // E1, E2 passed
    int_clr = 2'b11;           // sampled at E4 together with the set
    @(negedge clk);            // E3 passed, clr also sampled at E3
    @(negedge clk);            // E4 passed
    int_clr = 2'b00;
    check("R7 set wins over clear", int_raw, 3);

    // R5: masking and irq
    int_ena = 2'b01; #1;
    check("R5 st with ena 01", int_st, 1);
    check("R5 irq with ena 01", hung_irq, 1);
    int_ena = 2'b10; #1;
    check("R5 st with ena 10", int_st, 2);
    int_ena = 2'b00; #1;
    check("R5 st with ena 00", int_st, 0);
    check("R5 irq with ena 00", hung_irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule